// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block is the clock and framing source for a serial audio port that runs as master. It divides a reference clock by a programmable ratio to make the bit clock. It then counts bit clocks to build frames, and drives a frame-sync pin whose period and active width are programmed separately. Because the width is its own setting, the same counter serves two kinds of framing. A width of half the frame gives the 50% duty sync used by I2S and left-justified links. A width of zero gives the single-bit pulse used by DSP-style links.

A polarity bit selects whether the sync is active low or active high. A one-cycle frame-start strobe marks the first reference cycle of every frame, so that a neighbouring shifter can load its next word.

The block also checks bandwidth. Before it starts, the frame length must be at least the slot width times the slot count. If it is not, the block will not start and it flags the setting as rejected.

The settings are copied into the block every cycle while the generator is stopped. While it runs, a new setting is taken only at a frame boundary. The block has no data stream: every pin is plain control or status, and none has back-pressure.

Top module: `audio_fsync_gen`

## Requirements
- R1: With divider field D, each bit-clock period lasts N = D+1 reference cycles. For N ≥ 2 the bit clock is high for the first ceil(N/2) of those cycles and low for the rest. For N = 1 the reference clock itself is passed to `bit_clk` while running.
- R2: With period field P, a frame lasts P+1 bit clocks. `frame_start` is high for exactly the first reference cycle of bit 0 of each frame.
- R3: With width field W, the sync is active for bit clocks 0 through W of each frame. If W ≥ P, it is active for the whole frame.
- R4: With `fs_high` = 0 the sync is active low, and with `fs_high` = 1 it is active high. When not running, `frame_sync` rests at the inactive level.
- R5: The generator starts only if (P+1) ≥ `slot_bits` × `slot_cnt`; equality is accepted. `cfg_reject` is 1 in the cycle after the inputs fail this test, and 0 in the cycle after they pass it.
- R6: A setting changed while running takes effect at the next frame boundary. A setting that fails the R5 test at a boundary is ignored, and the previous frame format continues.
- R7: Outputs lag the internal state by one register. The first `frame_start` appears in the second cycle after the first clock edge that sees `en` high. After the first edge that sees `en` low, `bit_clk` and `frame_start` are 0 and `frame_sync` is inactive by the following edge.
- R8: After reset, `bit_clk` = 0, `frame_start` = 0, `cfg_reject` = 0 and `frame_sync` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request |
| div_m1 | input | 8 | Bit-clock divide ratio minus one |
| per_m1 | input | 12 | Bit clocks per frame minus one |
| wid_m1 | input | 8 | Active sync length in bit clocks minus one |
| fs_high | input | 1 | 1: sync active high; 0: active low |
| slot_bits | input | 6 | Bits per slot, used by the bandwidth check |
| slot_cnt | input | 5 | Slots per frame, used by the bandwidth check |
| bit_clk | output | 1 | Generated bit clock |
| frame_sync | output | 1 | Frame-sync pin |
| frame_start | output | 1 | One-cycle strobe at the start of a frame |
| cfg_reject | output | 1 | Inputs fail the bandwidth check |

## Verification
The embedded properties check the following on every cycle:
- The divider and bit counters never pass their programmed limits.
- The bit clock rises only after a divider count of zero.
- The start strobe always falls inside the active sync.
- The active setting holds still between frame boundaries.
- A failing setting holds off the start.
- No strobe appears unless the generator was running.

Only the bench scenarios show the cycle-exact behaviour: the bit-clock duty and period, the frame length, the sync width and polarity, the pass-through at ratio one, and which boundary takes up a changed or rejected setting.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int DIV_W  = 8;
  localparam int PER_W  = 12;
  localparam int WID_W  = 8;
  localparam int SLOT_W = 6;
  localparam int SCNT_W = 5;
  localparam int NEED_W = SLOT_W + SCNT_W;
  localparam int PAD_W  = PER_W + 1 - NEED_W;

  typedef struct packed {
    logic [DIV_W-1:0] div_m1;
    logic [PER_W-1:0] per_m1;
    logic [WID_W-1:0] wid_m1;
    logic             fs_high;
  } fsg_cfg_t;

  // frame length in bit clocks must cover every slot bit
  function automatic logic bw_ok(input logic [PER_W-1:0]  per_m1,
                                 input logic [SLOT_W-1:0] bits,
                                 input logic [SCNT_W-1:0] cnt);
    logic [PER_W:0]    frame_len;
    logic [NEED_W-1:0] need;
    frame_len = {1'b0, per_m1} + 1'b1;
    need      = NEED_W'(bits) * NEED_W'(cnt);
    return frame_len >= {{PAD_W{1'b0}}, need};
  endfunction
endpackage

// File: rtl/fsg_cfg_hold.sv
module fsg_cfg_hold
  import fsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              frame_end,
  input  fsg_cfg_t          cfg_in,
  input  logic [SLOT_W-1:0] slot_bits,
  input  logic [SCNT_W-1:0] slot_cnt,
  output logic              run,
  output fsg_cfg_t          cfg_act,
  output logic              reject
);
  logic ok;

  assign ok = bw_ok(cfg_in.per_m1, slot_bits, slot_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      cfg_act <= '0;
      reject  <= 1'b0;
    end else begin
      reject <= !ok;
      run    <= en & (run | ok);
      if (!run || (frame_end && ok))
        cfg_act <= cfg_in;
    end
  end

  // R5
  start_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ok) |=> !run);

  // R6
  cfg_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && run && !$past(frame_end)) |-> $stable(cfg_act));
endmodule

// File: rtl/fsg_bit_div.sv
module fsg_bit_div #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick,
  output logic          dcnt_zero,
  output logic          bclk_q
);
  logic [DW-1:0] dcnt;
  logic          wrap;
  logic [DW-1:0] half;

  assign wrap      = (dcnt == div);
  assign tick      = run & wrap;
  assign dcnt_zero = (dcnt == '0);
  assign half      = div >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt   <= '0;
      bclk_q <= 1'b0;
    end else begin
      bclk_q <= run & (dcnt <= half);
      if (!run || wrap) dcnt <= '0;
      else              dcnt <= dcnt + 1'b1;
    end
  end

  // R1
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (dcnt <= div));

  // R1
  bclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_q) |-> ($past(dcnt) == '0));
endmodule

// File: rtl/fsg_frame_ctr.sv
module fsg_frame_ctr #(
  parameter int PW = 12,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic          dcnt_zero,
  input  logic [PW-1:0] per,
  input  logic [WW-1:0] wid,
  input  logic          fs_high,
  output logic          frame_end,
  output logic          fs_pin,
  output logic          fstart
);
  localparam int XW = PW - WW;

  logic [PW-1:0] bcnt;
  logic          act_n;
  logic          fs_act_q;

  assign frame_end = tick & (bcnt == per);
  assign act_n     = run & (bcnt <= {{XW{1'b0}}, wid});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt     <= '0;
      fs_act_q <= 1'b0;
      fs_pin   <= 1'b1;
      fstart   <= 1'b0;
    end else begin
      fs_act_q <= act_n;
      fs_pin   <= act_n ~^ fs_high;
      fstart   <= run & dcnt_zero & (bcnt == '0);
      if (!run || frame_end) bcnt <= '0;
      else if (tick)         bcnt <= bcnt + 1'b1;
    end
  end

  // R2
  bcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (bcnt <= per));

  // R3
  start_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fstart |-> fs_act_q);
endmodule

// File: rtl/audio_fsync_gen.sv
module audio_fsync_gen
  import fsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  div_m1,
  input  logic [PER_W-1:0]  per_m1,
  input  logic [WID_W-1:0]  wid_m1,
  input  logic              fs_high,
  input  logic [SLOT_W-1:0] slot_bits,
  input  logic [SCNT_W-1:0] slot_cnt,
  output logic              bit_clk,
  output logic              frame_sync,
  output logic              frame_start,
  output logic              cfg_reject
);
  fsg_cfg_t cfg_in;
  fsg_cfg_t cfg_act;
  logic     run;
  logic     frame_end;
  logic     tick;
  logic     dcnt_zero;
  logic     bclk_q;
  logic     pass_q;

  assign cfg_in = '{div_m1: div_m1, per_m1: per_m1, wid_m1: wid_m1, fs_high: fs_high};

  fsg_cfg_hold u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .frame_end (frame_end),
    .cfg_in    (cfg_in),
    .slot_bits (slot_bits),
    .slot_cnt  (slot_cnt),
    .run       (run),
    .cfg_act   (cfg_act),
    .reject    (cfg_reject)
  );

  fsg_bit_div #(.DW(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .div       (cfg_act.div_m1),
    .tick      (tick),
    .dcnt_zero (dcnt_zero),
    .bclk_q    (bclk_q)
  );

  fsg_frame_ctr #(.PW(PER_W), .WW(WID_W)) u_frm (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .dcnt_zero (dcnt_zero),
    .per       (cfg_act.per_m1),
    .wid       (cfg_act.wid_m1),
    .fs_high   (cfg_act.fs_high),
    .frame_end (frame_end),
    .fs_pin    (frame_sync),
    .fstart    (frame_start)
  );

  // ratio one: registered select, aligned with the other outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pass_q <= 1'b0;
    else        pass_q <= run & (cfg_act.div_m1 == '0);
  end

  assign bit_clk = pass_q ? clk : bclk_q;

  // R7
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !frame_start);
endmodule

// File: tb/sim_audio_fsync_gen.sv
module sim_audio_fsync_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [7:0]  div_m1 = '0;
  logic [11:0] per_m1 = '0;
  logic [7:0]  wid_m1 = '0;
  logic        fs_high = 1'b0;
  logic [5:0]  slot_bits = '0;
  logic [4:0]  slot_cnt = '0;
  logic        bit_clk, frame_sync, frame_start, cfg_reject;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  audio_fsync_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .div_m1(div_m1), .per_m1(per_m1),
    .wid_m1(wid_m1), .fs_high(fs_high), .slot_bits(slot_bits), .slot_cnt(slot_cnt),
    .bit_clk(bit_clk), .frame_sync(frame_sync), .frame_start(frame_start),
    .cfg_reject(cfg_reject)
  );

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_combo(input int n, input int p, input int w, input bit inv);
    @(negedge clk);
    en = 1'b0; div_m1 = 8'(n-1); per_m1 = 12'(p-1); wid_m1 = 8'(w);
    fs_high = inv; slot_bits = 6'd1; slot_cnt = 5'd1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(posedge clk);
    for (int t = 0; t < 2*n*p; t++) begin
      int  d, b;
      bit  eb, act, efs, est;
      @(posedge clk); #2;
      d   = t % n;
      b   = (t / n) % p;
      eb  = (n == 1) ? 1'b1 : (d <= (n-1)/2);
      act = (b <= w);
      efs = inv ? act : !act;
      est = ((t % (n*p)) == 0);
      chk(bit_clk == eb, "R1 bit clock", int'(bit_clk), int'(eb));
      chk(frame_start == est, "R2 frame start", int'(frame_start), int'(est));
      chk(frame_sync == efs, "R3 R4 frame sync", int'(frame_sync), int'(efs));
    end
    if (n == 1) begin
      @(negedge clk); #1;
      chk(bit_clk == 1'b0, "R1 pass-through low phase", int'(bit_clk), 0);
    end
    @(negedge clk); en = 1'b0;
    @(posedge clk); @(posedge clk); #2;
    chk(bit_clk == 1'b0, "R7 idle bit clock", int'(bit_clk), 0);
    chk(frame_start == 1'b0, "R7 idle strobe", int'(frame_start), 0);
    chk(frame_sync == !inv, "R7 R4 idle sync level", int'(frame_sync), int'(!inv));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(bit_clk == 1'b0, "R8 reset bit clock", int'(bit_clk), 0);
    chk(frame_sync == 1'b1, "R8 reset sync", int'(frame_sync), 1);
    chk(frame_start == 1'b0, "R8 reset strobe", int'(frame_start), 0);
    chk(cfg_reject == 1'b0, "R8 reset reject", int'(cfg_reject), 0);
    @(negedge clk); rst_n = 1'b1;

    // sweep R1 R2 R3 R4 R7
    for (int n = 1; n <= 4; n++)
      for (int pi = 0; pi < 3; pi++)
        for (int wi = 0; wi < 3; wi++)
          for (int inv = 0; inv < 2; inv++) begin
            int p, w;
            p = 4 << pi;
            w = (wi == 0) ? 0 : (wi == 1) ? p/2 - 1 : p - 1;
            run_combo(n, p, w, inv[0]);
          end

    // R5: too little bandwidth, then the exact fit
    @(negedge clk);
    en = 1'b0; div_m1 = 8'd1; per_m1 = 12'd7; wid_m1 = 8'd0; fs_high = 1'b0;
    slot_bits = 6'd4; slot_cnt = 5'd3;
    repeat (3) @(negedge clk);
    en = 1'b1;
    for (int t = 0; t < 30; t++) begin
      @(posedge clk); #2;
      chk(frame_start == 1'b0, "R5 no start when rejected", int'(frame_start), 0);
      chk(bit_clk == 1'b0, "R5 no bit clock when rejected", int'(bit_clk), 0);
      chk(frame_sync == 1'b1, "R5 sync idle when rejected", int'(frame_sync), 1);
      chk(cfg_reject == 1'b1, "R5 reject flag", int'(cfg_reject), 1);
    end
    @(negedge clk); slot_cnt = 5'd2;
    @(posedge clk); @(posedge clk); #2;
    chk(frame_start == 1'b1, "R5 equality accepted", int'(frame_start), 1);
    chk(cfg_reject == 1'b0, "R5 reject cleared", int'(cfg_reject), 0);
    @(negedge clk); en = 1'b0;
    repeat (3) @(negedge clk);

    // R6: change at boundary, then a rejected change ignored
    div_m1 = 8'd0; per_m1 = 12'd3; wid_m1 = 8'd0; fs_high = 1'b1;
    slot_bits = 6'd1; slot_cnt = 5'd1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(posedge clk);
    for (int t = 0; t <= 24; t++) begin
      bit est;
      @(posedge clk); #2;
      est = (t == 0) || (t == 4) || (t == 12) || (t == 20);
      chk(frame_start == est, "R6 boundary update", int'(frame_start), int'(est));
      if (t == 1) per_m1 = 12'd7;
      if (t == 13) begin per_m1 = 12'd1; slot_bits = 6'd4; slot_cnt = 5'd1; end
    end
    chk(cfg_reject == 1'b1, "R6 R5 rejected change flagged", int'(cfg_reject), 1);
    @(negedge clk); en = 1'b0;
    @(posedge clk); @(posedge clk); #2;
    chk(frame_sync == 1'b0, "R7 idle active-high sync", int'(frame_sync), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule